// File: doc/BRIEF.md
# Parallel Sampling Converter Sequencer

This block sits on the host side of a 12-bit parallel sampling converter. It drives the converter's active-low chip select, conversion start, read and power-down lines. It watches the converter's active-low busy flag and captures the result word. The host sees a level request and a one-cycle valid strobe that comes with the captured word. Every analog-side minimum time is a parameter counted in clock cycles. The defaults assume a 10 ns clock: setup 2 cycles, start low 4 cycles, early-release window 12 cycles, read access 17 cycles, bus float 9 cycles, wake-up 35 cycles, throughput 200 cycles and busy timeout 400 cycles.

While `req` is high and the controller is idle and awake, the controller runs one conversion. The `mode` input is sampled when the conversion begins.
- Plain mode: read stays low and the word is taken when busy rises.
- Strobe mode: read is pulsed only after busy has risen, and the word is taken after the access allowance.
- Tied mode: read and start move as one line, held low from the start of the conversion until capture.

The busy flag passes through a two-flop synchronizer before any edge is looked for. `sleep` puts the converter into power-down between conversions. On wake-up the controller holds off the next start until the wake-up time has passed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, `adc_sel_n`, `adc_start_n`, `adc_rd_n` and `adc_shdn_n` are 1, and `out_valid` and `timeout_err` are 0.
- R2: After reset, `adc_sel_n` is driven low and stays low. A falling edge of `adc_start_n` happens only with `adc_sel_n` low, at least T_SETUP cycles after `adc_sel_n` fell.
- R3: In plain and strobe modes, `adc_start_n` stays low for exactly T_LOW cycles (T_LOW < T_EARLY), so it returns high before the first bit decision.
- R4: Two falling edges of `adc_start_n` are at least T_THRU cycles apart. With `req` held high, conversions follow each other back to back.
- R5: Mode codes 0 and 3 select plain mode. `adc_rd_n` is held low, and on the synchronized rise of busy the word on `adc_data` is placed on `out_data` with `out_valid` high for one cycle.
- R6: Mode code 1 selects strobe mode. `adc_rd_n` goes low only after busy has risen. The word is captured T_ACC cycles after `adc_rd_n` falls, and at that moment `adc_rd_n` returns high.
- R7: Mode code 2 selects tied mode. `adc_rd_n` equals `adc_start_n` throughout a conversion: both go low at the start and both rise in the cycle the word is captured, after busy has risen.
- R8: A falling edge of `adc_start_n` comes no sooner than T_FLOAT cycles after the last rise of `adc_rd_n`.
- R9: With `sleep` high while idle, `adc_shdn_n` goes low. While it is low, `adc_start_n` stays high and `req` starts nothing.
- R10: A falling edge of `adc_start_n` comes at least T_WAKE cycles after `adc_shdn_n` rises.
- R11: If busy has not fallen and risen again within T_TIMEOUT cycles of the start falling edge, `timeout_err` pulses for one cycle. In that case no `out_valid` is produced, `adc_start_n` returns high and the controller accepts new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Sequencing scheme: 0/3 plain, 1 strobe, 2 tied |
| req | input | 1 | Level request for conversions |
| sleep | input | 1 | Request converter power-down while idle |
| adc_busy_n | input | 1 | Converter busy flag, low while converting (asynchronous) |
| adc_data | input | W | Converter data bus |
| adc_sel_n | output | 1 | Chip select, active low |
| adc_start_n | output | 1 | Conversion start, falling edge starts |
| adc_rd_n | output | 1 | Read enable, active low |
| adc_shdn_n | output | 1 | Power-down, low puts converter to sleep |
| out_valid | output | 1 | One-cycle strobe with a captured word |
| out_data | output | W | Captured conversion word |
| timeout_err | output | 1 | One-cycle pulse when busy never completes |

## Verification
The assertions assume the converter behaves as specified. After a start edge, busy falls within a few cycles and rises again well inside the timeout. The data bus holds the result from just before busy rises until the next conversion. In strobe mode the data is valid sooner than T_ACC cycles after read falls. The bench's converter model keeps to this: busy falls 3 cycles after a start, the conversion lasts 150 cycles, and the data bus shows a poison pattern until read has been low for 10 cycles. Its one deliberate breach is a model that never answers, which exists only to exercise the timeout.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int W         = 12,
  parameter int T_SETUP   = 2,
  parameter int T_LOW     = 4,
  parameter int T_ACC     = 17,
  parameter int T_FLOAT   = 9,
  parameter int T_WAKE    = 35,
  parameter int T_THRU    = 200,
  parameter int T_TIMEOUT = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         req,
  input  logic         sleep,
  input  logic         adc_busy_n,
  input  logic [W-1:0] adc_data,
  output logic         adc_sel_n,
  output logic         adc_start_n,
  output logic         adc_rd_n,
  output logic         adc_shdn_n,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         timeout_err
);

  localparam int SETUP_LEN = (T_SETUP > T_FLOAT) ? T_SETUP : T_FLOAT;
  localparam int LIM       = T_TIMEOUT + T_THRU + T_WAKE + T_ACC + SETUP_LEN + 2;
  localparam int CW        = $clog2(LIM + 1);

  localparam logic [CW-1:0] C_SETUP = CW'(SETUP_LEN - 1);
  localparam logic [CW-1:0] C_LOW   = CW'(T_LOW - 1);
  localparam logic [CW-1:0] C_ACC   = CW'(T_ACC - 1);
  localparam logic [CW-1:0] C_FLOAT = CW'(T_FLOAT - 1);
  localparam logic [CW-1:0] C_WAKE  = CW'(T_WAKE);
  localparam logic [CW-1:0] C_THRU  = CW'(T_THRU);
  localparam logic [CW-1:0] C_TOUT  = CW'(T_TIMEOUT);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_WAIT, S_READ, S_FLOAT} st_t;
  typedef enum logic [1:0] {K_PLAIN, K_STROBE, K_TIED} kind_t;

  st_t     st;
  kind_t   kind_q;
  logic [CW-1:0] cnt, thr_cnt, wake_cnt;
  logic    bsy_m, bsy_s, seen_lo;

  kind_t kind_in;
  assign kind_in = (mode == 2'd1) ? K_STROBE : (mode == 2'd2) ? K_TIED : K_PLAIN;

  logic go, done_busy;
  assign go        = (cnt >= C_SETUP) && (thr_cnt >= C_THRU) && (wake_cnt >= C_WAKE);
  assign done_busy = seen_lo && bsy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_m <= 1'b1;
      bsy_s <= 1'b1;
    end else begin
      bsy_m <= adc_busy_n;
      bsy_s <= bsy_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= C_WAKE;
    end else if (!adc_shdn_n) begin
      wake_cnt <= '0;
    end else if (wake_cnt < C_WAKE) begin
      wake_cnt <= wake_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kind_q      <= K_PLAIN;
      cnt         <= '0;
      thr_cnt     <= C_THRU;
      seen_lo     <= 1'b0;
      adc_sel_n   <= 1'b1;
      adc_start_n <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_shdn_n  <= 1'b1;
      out_valid   <= 1'b0;
      out_data    <= '0;
      timeout_err <= 1'b0;
    end else begin
      adc_sel_n   <= 1'b0;
      out_valid   <= 1'b0;
      timeout_err <= 1'b0;
      if (thr_cnt < C_THRU) thr_cnt <= thr_cnt + 1'b1;
      if ((st == S_LOW || st == S_WAIT) && !bsy_s) seen_lo <= 1'b1;
      if (cnt < CW'(LIM)) cnt <= cnt + 1'b1;

      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (sleep) begin
            adc_shdn_n <= 1'b0;
          end else begin
            adc_shdn_n <= 1'b1;
            if (req && adc_shdn_n) begin
              st     <= S_SETUP;
              kind_q <= kind_in;
              adc_rd_n <= (kind_in == K_PLAIN) ? 1'b0 : 1'b1;
            end
          end
        end

        S_SETUP: begin
          if (go) begin
            st          <= S_LOW;
            cnt         <= '0;
            thr_cnt     <= '0;
            seen_lo     <= 1'b0;
            adc_start_n <= 1'b0;
            if (kind_q == K_TIED) adc_rd_n <= 1'b0;
          end
        end

        S_LOW: begin
          if (cnt >= C_LOW) begin
            st <= S_WAIT;
            if (kind_q != K_TIED) adc_start_n <= 1'b1;
          end
        end

        S_WAIT: begin
          if (done_busy) begin
            case (kind_q)
              K_STROBE: begin
                st       <= S_READ;
                cnt      <= '0;
                adc_rd_n <= 1'b0;
              end
              K_TIED: begin
                st          <= S_FLOAT;
                cnt         <= '0;
                out_data    <= adc_data;
                out_valid   <= 1'b1;
                adc_start_n <= 1'b1;
                adc_rd_n    <= 1'b1;
              end
              default: begin
                st        <= S_FLOAT;
                cnt       <= '0;
                out_data  <= adc_data;
                out_valid <= 1'b1;
              end
            endcase
          end else if (cnt >= C_TOUT) begin
            st          <= S_FLOAT;
            cnt         <= '0;
            timeout_err <= 1'b1;
            adc_start_n <= 1'b1;
            adc_rd_n    <= (kind_q == K_PLAIN) ? 1'b0 : 1'b1;
          end
        end

        S_READ: begin
          if (cnt >= C_ACC) begin
            st        <= S_FLOAT;
            cnt       <= '0;
            out_data  <= adc_data;
            out_valid <= 1'b1;
            adc_rd_n  <= 1'b1;
          end
        end

        S_FLOAT: begin
          if (cnt >= C_FLOAT) st <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SEL_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start_n) |-> !adc_sel_n); // R2

  AST_THRU_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start_n) |-> $past(thr_cnt) >= C_THRU); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5

  AST_RD_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_STROBE && !adc_rd_n) |-> bsy_s); // R6

  AST_TIED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_TIED && st != S_IDLE) |-> (adc_rd_n == adc_start_n)); // R7

  AST_SLEEP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_shdn_n |-> adc_start_n); // R9

  AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_start_n) |-> $past(wake_cnt) >= C_WAKE); // R10

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!out_valid && adc_start_n)); // R11

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12, T_SETUP = 2, T_LOW = 4, T_ACC = 17, T_FLOAT = 9;
  localparam int T_WAKE = 35, T_THRU = 200, T_TIMEOUT = 400;
  localparam int CONV = 150;
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 12'h000}, {2'd1, 12'hFFF}, {2'd2, 12'h800}, {2'd3, 12'h7FF},
    {2'd1, 12'hA5A}, {2'd2, 12'h5A5}, {2'd0, 12'h001}, {2'd2, 12'h123}};

  logic clk = 0, rst_n = 0, req = 0, sleep = 0;
  logic [1:0] mode = 0;
  logic adc_sel_n, adc_start_n, adc_rd_n, adc_shdn_n, out_valid, timeout_err;
  logic [W-1:0] out_data, adc_data;

  logic m_busy_n = 1, m_run = 0, m_dead = 0, prev_start = 1, prev_rd = 1, prev_shdn = 1, prev_sel = 1;
  logic [W-1:0] m_word = 12'h000, m_next = 12'h000;
  int m_cnt = 0, rdlo = 0, cyc = 0;
  int last_fall = -100000, sel_fall = -100000, rd_rise = -100000, shdn_rise = -100000, fall_at = 0;
  int nfalls = 0, last_gap = 0, last_width = 0, first_setup = -1;
  int v_thru = 0, v_width = 0, v_rdbusy = 0, v_tied = 0, v_float = 0, v_wake = 0, v_shdn = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign adc_data = (rdlo >= 10) ? m_word : 12'hBAD;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .sleep(sleep),
    .adc_busy_n(m_busy_n), .adc_data(adc_data), .adc_sel_n(adc_sel_n),
    .adc_start_n(adc_start_n), .adc_rd_n(adc_rd_n), .adc_shdn_n(adc_shdn_n),
    .out_valid(out_valid), .out_data(out_data), .timeout_err(timeout_err));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_sel && !adc_sel_n) sel_fall = cyc;
    if (!prev_shdn && adc_shdn_n) shdn_rise = cyc;
    if (!prev_rd && adc_rd_n) rd_rise = cyc;
    if (prev_start && !adc_start_n) begin
      nfalls = nfalls + 1;
      last_gap = cyc - last_fall;
      if (last_gap < T_THRU) v_thru = v_thru + 1;
      if (cyc - rd_rise < T_FLOAT) v_float = v_float + 1;
      if (cyc - shdn_rise < T_WAKE) v_wake = v_wake + 1;
      if (first_setup < 0) first_setup = cyc - sel_fall;
      last_fall = cyc;
      fall_at = cyc;
      if (!m_run && !m_dead && !adc_sel_n && adc_shdn_n) begin
        m_run = 1;
        m_cnt = 0;
      end
    end
    if (!prev_start && adc_start_n) begin
      last_width = cyc - fall_at;
      if (mode != 2'd2 && last_width != T_LOW) v_width = v_width + 1;
      if (mode == 2'd2 && (!m_busy_n || !adc_rd_n)) v_tied = v_tied + 1;
    end
    if (mode == 2'd2 && !adc_start_n && adc_rd_n) v_tied = v_tied + 1;
    if (mode == 2'd1 && !adc_rd_n && !m_busy_n) v_rdbusy = v_rdbusy + 1;
    if (!adc_shdn_n && !adc_start_n) v_shdn = v_shdn + 1;
    if (m_run) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == 3) m_busy_n = 0;
      if (m_cnt == CONV - 1) m_word = m_next;
      if (m_cnt == CONV) begin
        m_busy_n = 1;
        m_run = 0;
      end
    end
    if (!adc_rd_n && !adc_sel_n) rdlo = rdlo + 1;
    else rdlo = 0;
    prev_start = adc_start_n;
    prev_rd = adc_rd_n;
    prev_shdn = adc_shdn_n;
    prev_sel = adc_sel_n;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got, output logic [W-1:0] word);
    got = 0;
    word = '0;
    for (int i = 0; i < 1000 && !got; i++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1;
        word = out_data;
      end
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  initial begin
    bit got;
    logic [W-1:0] w;
    int n0, t0;
    repeat (4) @(negedge clk);
    check(adc_sel_n && adc_start_n && adc_rd_n && adc_shdn_n, "R1 pins in reset",
          {adc_sel_n, adc_start_n, adc_rd_n, adc_shdn_n}, 4'hF);
    check(!out_valid && !timeout_err, "R1 flags in reset", {out_valid, timeout_err}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!adc_sel_n, "R2 select low after reset", adc_sel_n, 0);

    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][13:12];
      m_next = VEC[v][11:0];
      req = 1;
      wait_valid(got, w);
      req = 0;
      check(got && w == VEC[v][11:0],
            (mode == 1) ? "R6 strobe word" : (mode == 2) ? "R7 tied word" : "R5 plain word",
            w, VEC[v][11:0]);
      if (mode == 2'd1) check(adc_rd_n == 1, "R6 read released at capture", adc_rd_n, 1);
      else if (mode == 2'd2) check(adc_rd_n && adc_start_n, "R7 tied released at capture",
                                   {adc_rd_n, adc_start_n}, 2'b11);
      else check(adc_rd_n == 0, "R5 read held low", adc_rd_n, 0);
      @(negedge clk);
      check(!out_valid, "R5 valid one cycle", out_valid, 0);
    end
    check(first_setup >= T_SETUP, "R2 select to start setup", first_setup, T_SETUP);

    mode = 0;
    m_next = 12'h3C3;
    req = 1;
    wait_valid(got, w);
    m_next = 12'hC3C;
    wait_valid(got, w);
    req = 0;
    check(got && w == 12'hC3C, "R4 back-to-back word", w, 12'hC3C);
    check(last_gap >= T_THRU && last_gap < T_THRU + 20, "R4 back-to-back gap", last_gap, T_THRU);
    check(last_width == T_LOW, "R3 start low width", last_width, T_LOW);

    repeat (40) @(negedge clk);
    sleep = 1;
    repeat (5) @(negedge clk);
    check(!adc_shdn_n, "R9 shutdown driven", adc_shdn_n, 0);
    n0 = nfalls;
    req = 1;
    mode = 1;
    m_next = 12'h6E6;
    repeat (300) @(negedge clk);
    check(nfalls == n0 && !out_valid, "R9 request ignored asleep", nfalls - n0, 0);
    sleep = 0;
    wait_valid(got, w);
    req = 0;
    check(got && w == 12'h6E6, "R10 word after wake", w, 12'h6E6);
    check(last_fall - shdn_rise >= T_WAKE, "R10 wake delay", last_fall - shdn_rise, T_WAKE);

    repeat (20) @(negedge clk);
    m_dead = 1;
    mode = 0;
    req = 1;
    got = 0;
    t0 = 0;
    for (int i = 0; i < T_TIMEOUT + 300 && !got; i++) begin
      @(negedge clk);
      if (out_valid) t0 = t0 + 1;
      if (timeout_err) begin
        got = 1;
        check(adc_start_n, "R11 start released on timeout", adc_start_n, 1);
      end
    end
    check(got && t0 == 0, "R11 timeout flagged without word", {got, t0[0]}, 2'b10);
    @(negedge clk);
    check(!timeout_err, "R11 timeout one cycle", timeout_err, 0);
    m_dead = 0;
    m_next = 12'h0F0;
    wait_valid(got, w);
    req = 0;
    check(got && w == 12'h0F0, "R11 recovery word", w, 12'h0F0);

    check(v_thru == 0, "R4 start spacing", v_thru, 0);
    check(v_width == 0, "R3 start widths", v_width, 0);
    check(v_rdbusy == 0, "R6 read while busy", v_rdbusy, 0);
    check(v_tied == 0, "R7 read/start pairing", v_tied, 0);
    check(v_float == 0, "R8 bus float gap", v_float, 0);
    check(v_wake == 0, "R10 wake spacing", v_wake, 0);
    check(v_shdn == 0, "R9 start while asleep", v_shdn, 0);
    finished = 1;
    summary();
  end
endmodule